// File: doc/BRIEF.md
# Two-Agent Priority Bus Arbiter

This block decides which of two agents owns a shared request bus. One agent is symmetric and normally holds the bus. The other is a high-priority agent that can take the bus away. Both request lines are active low and are sampled on the rising clock edge. When the priority request is seen, the symmetric agent loses permission to start new requests. The one exception is a locked sequence the symmetric agent has already begun. That sequence runs to its last request before preemption takes effect.

The arbiter counts the priority agent's outstanding transactions, adding one per issue strobe and removing one per completion strobe. Ownership returns to the symmetric agent only when two things hold: the priority request has been withdrawn and the count has drained to zero. When neither agent asks for the bus, the symmetric agent keeps it parked and may issue at once.

Top module: `bus_prio_arbiter`

## Requirements
- R1: With `rst` high at a rising edge, after that edge the outstanding count is 0, `lock_held` is 0, `bus_owner` is 0 (symmetric), `sym_issue_ok` is 1 and `sym_wait` is 0.
- R2: If `prio_req_n` is low at edge k and no lock is held, then from edge k+1 onward `sym_issue_ok` is 0 and `bus_owner` is 1 (priority).
- R3: After the priority agent owns the bus, ownership and `sym_issue_ok` stay with it for as long as either the sampled priority request is active or the outstanding count is nonzero. If the request is high at edge k and the count is already zero after edge k, then after edge k+1 `bus_owner` is 0 and `sym_issue_ok` is 1.
- R4: `prio_pending` rises by one on an edge that sees only `prio_issue` and falls by one on an edge that sees only `prio_done`. It is unchanged when both strobes are high together.
- R5: When `prio_pending` equals MAX_OUTSTANDING, a lone `prio_issue` leaves it unchanged.
- R6: When `prio_pending` is zero, a lone `prio_done` leaves it at zero.
- R7: A symmetric issue is accepted when `sym_issue` is high while `sym_issue_ok` is 1. An accepted issue with `sym_locked`=1 and `sym_lock_last`=0 sets `lock_held` after that edge. An accepted issue with `sym_locked`=1 and `sym_lock_last`=1 clears it.
- R8: While `lock_held` is 1, an active priority request changes neither `sym_issue_ok` (it stays 1) nor `bus_owner`. Preemption follows one edge after the lock clears.
- R9: A `sym_issue` made while `sym_issue_ok` is 0 does not change `lock_held`.
- R10: With `prio_req_n` high and no priority transactions outstanding, the symmetric agent keeps the bus (`bus_owner`=0, `sym_issue_ok`=1) whatever `sym_req_n` does.
- R11: `sym_wait` is 1 exactly when the sampled symmetric request (low `sym_req_n` at the last edge) is active while `sym_issue_ok` is 0.
- R12: `prio_clear` is 1 exactly when `prio_pending` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prio_req_n | input | 1 | Priority agent bus request, active low |
| sym_req_n | input | 1 | Symmetric agent bus request, active low |
| sym_issue | input | 1 | Symmetric agent issues a request this cycle |
| sym_locked | input | 1 | The issued symmetric request belongs to a locked sequence |
| sym_lock_last | input | 1 | The issued locked request ends its sequence |
| prio_issue | input | 1 | Priority agent issues a transaction |
| prio_done | input | 1 | A priority transaction completes |
| sym_issue_ok | output | 1 | Symmetric agent may issue new requests |
| bus_owner | output | 1 | Current owner: 0 symmetric, 1 priority |
| sym_wait | output | 1 | Symmetric agent requesting but blocked |
| lock_held | output | 1 | A locked symmetric sequence is in progress |
| prio_pending | output | $clog2(MAX_OUTSTANDING+1) | Outstanding priority transactions |
| prio_clear | output | 1 | No priority transactions outstanding |

## Verification
The bench builds the arbiter with MAX_OUTSTANDING set to 3, so the counter reaches its ceiling after three issue strobes. That makes both the saturation case and the drain back to zero reachable within a short stimulus. The small limit also places a release of the priority request while transactions are still pending within a few cycles of the ceiling. The same run lets a locked sequence straddle the arrival of a priority request.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic {
        OWN_SYM  = 1'b0,
        OWN_PRIO = 1'b1
    } owner_e;

    typedef struct packed {
        logic prio;
        logic sym;
    } req_seen_s;

    function automatic logic [31:0] count_step(
        input logic [31:0] cur,
        input logic        inc,
        input logic        dec,
        input logic [31:0] lim
    );
        if (inc && !dec && (cur != lim)) return cur + 32'd1;
        if (dec && !inc && (cur != 32'd0)) return cur - 32'd1;
        return cur;
    endfunction

    function automatic logic lock_step(
        input logic cur,
        input logic accept,
        input logic locked,
        input logic last
    );
        if (accept && locked) return !last;
        return cur;
    endfunction

endpackage

// File: rtl/prio_track.sv
module prio_track
    import arb_pkg::*;
#(
    parameter int MAX_OUTSTANDING = 8,
    parameter int CW              = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prio_req_n,
    input  logic          sym_req_n,
    input  logic          prio_issue,
    input  logic          prio_done,
    output req_seen_s     seen,
    output logic [CW-1:0] cnt,
    output logic          cnt_zero
);
    localparam logic [31:0] LIM = 32'(MAX_OUTSTANDING);

    req_seen_s     seen_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    assign cnt_d = CW'(count_step(32'(cnt_q), prio_issue, prio_done, LIM));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            cnt_q  <= '0;
        end else begin
            seen_q.prio <= ~prio_req_n;
            seen_q.sym  <= ~sym_req_n;
            cnt_q       <= cnt_d;
        end
    end

    assign seen     = seen_q;
    assign cnt      = cnt_q;
    assign cnt_zero = (cnt_q == '0);

    // R4
    cnt_up_chk: assert property (@(posedge clk) disable iff (rst)
        (prio_issue && !prio_done && (32'(cnt_q) != LIM)) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ((32'(cnt_q) == LIM) && prio_issue && !prio_done) |=> (32'(cnt_q) == LIM));
    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        ((cnt_q == '0) && prio_done && !prio_issue) |=> (cnt_q == '0));
endmodule

// File: rtl/lock_track.sv
module lock_track
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic sym_locked,
    input  logic sym_lock_last,
    output logic lock_q
);
    logic lock_r;

    always_ff @(posedge clk) begin
        if (rst) lock_r <= 1'b0;
        else     lock_r <= lock_step(lock_r, accept, sym_locked, sym_lock_last);
    end

    assign lock_q = lock_r;

    // R9
    lock_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(lock_r));
    // R7
    lock_open_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && sym_locked && !sym_lock_last) |=> lock_r);
endmodule

// File: rtl/own_ctrl.sv
module own_ctrl
    import arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  req_seen_s seen,
    input  logic      lock_q,
    input  logic      cnt_zero,
    output logic      sym_ok,
    output owner_e    owner,
    output logic      sym_wait
);
    logic   ok_q;
    logic   ok_d;
    owner_e own_q;
    owner_e own_d;

    always_comb begin
        ok_d  = lock_q || (!seen.prio && cnt_zero);
        own_d = own_q;
        if (seen.prio && !lock_q)       own_d = OWN_PRIO;
        else if (!seen.prio && cnt_zero) own_d = OWN_SYM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q  <= 1'b1;
            own_q <= OWN_SYM;
        end else begin
            ok_q  <= ok_d;
            own_q <= own_d;
        end
    end

    assign sym_ok   = ok_q;
    assign owner    = own_q;
    assign sym_wait = seen.sym && !ok_q;

    // R2
    preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (seen.prio && !lock_q) |=> (!ok_q && (own_q == OWN_PRIO)));
    // R8
    lock_shield_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> ok_q);
    // R10
    park_chk: assert property (@(posedge clk) disable iff (rst)
        (!seen.prio && cnt_zero) |=> (ok_q && (own_q == OWN_SYM)));
    // R3
    hold_prio_chk: assert property (@(posedge clk) disable iff (rst)
        ((own_q == OWN_PRIO) && !cnt_zero) |=> (own_q == OWN_PRIO));
endmodule

// File: rtl/bus_prio_arbiter.sv
module bus_prio_arbiter
    import arb_pkg::*;
#(
    parameter int MAX_OUTSTANDING = 8,
    localparam int CW             = $clog2(MAX_OUTSTANDING + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          prio_req_n,
    input  logic          sym_req_n,
    input  logic          sym_issue,
    input  logic          sym_locked,
    input  logic          sym_lock_last,
    input  logic          prio_issue,
    input  logic          prio_done,
    output logic          sym_issue_ok,
    output logic          bus_owner,
    output logic          sym_wait,
    output logic          lock_held,
    output logic [CW-1:0] prio_pending,
    output logic          prio_clear
);
    req_seen_s     seen;
    logic [CW-1:0] cnt;
    logic          cnt_zero;
    logic          lock_q;
    logic          sym_ok;
    owner_e        owner;
    logic          accept;

    assign accept = sym_issue && sym_ok;

    prio_track #(.MAX_OUTSTANDING(MAX_OUTSTANDING), .CW(CW)) u_track (
        .clk        (clk),
        .rst        (rst),
        .prio_req_n (prio_req_n),
        .sym_req_n  (sym_req_n),
        .prio_issue (prio_issue),
        .prio_done  (prio_done),
        .seen       (seen),
        .cnt        (cnt),
        .cnt_zero   (cnt_zero)
    );

    lock_track u_lock (
        .clk           (clk),
        .rst           (rst),
        .accept        (accept),
        .sym_locked    (sym_locked),
        .sym_lock_last (sym_lock_last),
        .lock_q        (lock_q)
    );

    own_ctrl u_own (
        .clk      (clk),
        .rst      (rst),
        .seen     (seen),
        .lock_q   (lock_q),
        .cnt_zero (cnt_zero),
        .sym_ok   (sym_ok),
        .owner    (owner),
        .sym_wait (sym_wait)
    );

    assign sym_issue_ok = sym_ok;
    assign bus_owner    = (owner == OWN_PRIO);
    assign lock_held    = lock_q;
    assign prio_pending = cnt;
    assign prio_clear   = cnt_zero;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (sym_issue_ok && !bus_owner && !lock_held && (prio_pending == '0)));
    // R11
    wait_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        sym_wait |-> !sym_issue_ok);
endmodule

// File: tb/bus_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_prio_arbiter_tb_top;
    localparam int MAXO = 3;
    localparam int CW   = $clog2(MAXO + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prio_req_n = 1'b1, sym_req_n = 1'b1;
    logic sym_issue = 1'b0, sym_locked = 1'b0, sym_lock_last = 1'b0;
    logic prio_issue = 1'b0, prio_done = 1'b0;
    logic sym_issue_ok, bus_owner, sym_wait, lock_held, prio_clear;
    logic [CW-1:0] prio_pending;

    always #10 clk = ~clk;

    bus_prio_arbiter #(.MAX_OUTSTANDING(MAXO)) dut_i (
        .clk(clk), .rst(rst), .prio_req_n(prio_req_n), .sym_req_n(sym_req_n),
        .sym_issue(sym_issue), .sym_locked(sym_locked), .sym_lock_last(sym_lock_last),
        .prio_issue(prio_issue), .prio_done(prio_done),
        .sym_issue_ok(sym_issue_ok), .bus_owner(bus_owner), .sym_wait(sym_wait),
        .lock_held(lock_held), .prio_pending(prio_pending), .prio_clear(prio_clear)
    );

    typedef struct packed {
        logic ok; logic own; logic wt; logic lk; logic [CW-1:0] cnt; logic clr;
    } exp_s;

    exp_s  exp_q[$];
    string tag_q[$];
    int    n_vec = 0;
    int    n_bad = 0;

    // reference state kept from the requirements
    logic m_pseen = 0, m_sseen = 0, m_lock = 0, m_ok = 1, m_own = 0;
    int   m_cnt = 0;

    task automatic step(input logic r, input logic pn, input logic sn, input logic si,
                        input logic sl, input logic slast, input logic pi, input logic pd,
                        input string tag);
        logic acc, n_lock, n_ok, n_own;
        int n_cnt;
        exp_s e;
        rst = r; prio_req_n = pn; sym_req_n = sn; sym_issue = si;
        sym_locked = sl; sym_lock_last = slast; prio_issue = pi; prio_done = pd;
        @(posedge clk);
        #1;
        if (r) begin
            m_pseen = 0; m_sseen = 0; m_lock = 0; m_ok = 1; m_own = 0; m_cnt = 0;
        end else begin
            acc    = si && m_ok;                                   // R7
            n_lock = (acc && sl) ? !slast : m_lock;                // R7 R9
            n_cnt  = m_cnt;                                        // R4 R5 R6
            if (pi && !pd && m_cnt < MAXO) n_cnt = m_cnt + 1;
            if (pd && !pi && m_cnt > 0)    n_cnt = m_cnt - 1;
            n_ok   = m_lock || (!m_pseen && m_cnt == 0);           // R2 R3 R8
            n_own  = (m_pseen && !m_lock) ? 1'b1 :
                     ((!m_pseen && m_cnt == 0) ? 1'b0 : m_own);    // R3 R10
            m_lock = n_lock; m_cnt = n_cnt; m_ok = n_ok; m_own = n_own;
            m_pseen = !pn; m_sseen = !sn;
        end
        e.ok = m_ok; e.own = m_own; e.wt = m_sseen && !m_ok;       // R11
        e.lk = m_lock; e.cnt = CW'(m_cnt); e.clr = (m_cnt == 0);   // R12
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic cmp1(input string tag, input string f, input logic [CW-1:0] a,
                        input logic [CW-1:0] x);
        if (a !== x) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, f, a, x);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_s  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            cmp1(t, "sym_issue_ok", CW'(sym_issue_ok), CW'(e.ok));
            cmp1(t, "bus_owner",    CW'(bus_owner),    CW'(e.own));
            cmp1(t, "sym_wait",     CW'(sym_wait),     CW'(e.wt));
            cmp1(t, "lock_held",    CW'(lock_held),    CW'(e.lk));
            cmp1(t, "prio_pending", prio_pending,      e.cnt);
            cmp1(t, "prio_clear",   CW'(prio_clear),   CW'(e.clr));
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        //     rst pn sn si sl sla pi pd
        step(1, 1, 1, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 1, 1, 0, 1, 0, "R1");
        // parking, symmetric request toggling
        step(0, 1, 1, 0, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 1, 0, 0, 0, 0, "R10");
        step(0, 1, 1, 1, 0, 0, 0, 0, "R10");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R10");
        // priority takes the bus
        step(0, 0, 1, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 1, 0, 0, 0, 1, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 0, 1, 1, 0, 0, 0, "R11");
        step(0, 0, 0, 1, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 0, 0, 0, 1, 0, "R4");
        step(0, 0, 1, 0, 0, 0, 1, 0, "R5");
        step(0, 0, 1, 0, 0, 0, 1, 1, "R4");
        step(0, 0, 1, 0, 0, 0, 0, 1, "R4");
        // request withdrawn while transactions pending
        step(0, 1, 0, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 0, 0, 0, 0, 0, 1, "R3");
        step(0, 1, 0, 0, 0, 0, 0, 1, "R3");
        step(0, 1, 0, 0, 0, 0, 0, 0, "R12");
        step(0, 1, 1, 0, 0, 0, 0, 1, "R6");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R3");
        // locked sequence straddling a priority request
        step(0, 1, 0, 1, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 1, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
        step(0, 0, 0, 1, 1, 1, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R3");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R10");
        // single-request locked op: no lock retained
        step(0, 1, 1, 1, 1, 1, 0, 0, "R7");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R7");
        // mid-run reset
        step(0, 0, 0, 0, 0, 0, 1, 0, "R2");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(0, 1, 1, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule